// File: doc/BRIEF.md
# Multi-Plane Memory Access Router

This block sits between a byte-wide CPU port and four byte-wide memory planes. For every CPU access it works out which planes see a write strobe, what offset inside each plane is addressed, and which plane's byte is returned on a read. A small indexed register file sets the mapping. Software first writes a register number through an index port, then writes the value through a data port. A single 16-bit word write can also carry both at once.

Three address mappings are supported. In interleaved (odd/even) mode, even CPU addresses land in the even planes and odd addresses in the odd planes, at half the CPU address. This is the layout used for character and attribute bytes. In sequential mode, the CPU address passes straight through and the write mask alone picks the planes. This lets software edit the glyph plane on its own. In four-way chained mode, each plane holds every fourth byte. Software moves between layouts by placing the block in a hold state, reprogramming the mask and mode registers, and then releasing it. A three-state hold machine blocks plane writes while the layout is in flux.

The hold machine has three states. ST_RUN means writes pass. ST_SYNC_HOLD is entered when the control register is written with bit 0 set and bit 1 clear. ST_ASYNC_HOLD is entered when the control register is written with bit 0 clear. Any control write moves the machine to the state that value selects, and a value of 0x03 returns it to ST_RUN. Writes to other registers never change the state.

Top module: `plane_access_router`

## Requirements
- R1: After reset, the register values are control = 0x03, write mask = 0x03, memory mode = 0x02 and read-plane select = 0x00. The selected index is 0 and the hold machine is in ST_RUN.
- R2: A register-bus write with word mode set takes the index from bits 7:0 and the data from bits 15:8, and updates both in one cycle. In byte mode, port 0 loads the index and port 1 writes bits 7:0 into the register the index selects.
- R3: The register read data returns the register the current index selects. Control is at index 0 (2 bits), write mask at index 2 (4 bits), memory mode at index 4 (4 bits) and read-plane select at index 5 (2 bits). Bits that are not stored read as zero. Every other index reads as 0x00 and writes to it have no effect.
- R4: A control value with bit 0 clear holds in ST_ASYNC_HOLD. Otherwise, a value with bit 1 clear holds in ST_SYNC_HOLD. A value of 0x03 runs. In either hold state, every plane write enable stays low.
- R5: While held, writes to the mask, mode and read-select registers take effect and read back.
- R6: Odd/even mode is selected when mode bit 3 = 0 and mode bit 2 = 0. In this mode the plane offset is the CPU address shifted right by one. An even address enables planes 0 and 2, an odd address enables planes 1 and 3, and in both cases the enables are ANDed with the mask.
- R7: Sequential mode is selected when mode bit 3 = 0 and mode bit 2 = 1. The plane offset equals the CPU address and the write enables equal the mask.
- R8: Chained mode is selected when mode bit 3 = 1, whatever bit 2 holds. The offset is the address shifted right by two, and only plane addr[1:0] is enabled, gated by the mask.
- R9: The CPU read data is byte p of the plane read bus, where plane p holds bits 8p+7:8p. In sequential mode p is the read select. In odd/even mode p is {select bit 1, address bit 0}. In chained mode p is addr[1:0].
- R10: The plane write data equals the CPU write data. No plane write enable is raised unless both the request and the write strobe are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register bus write strobe |
| cfg_port | input | 1 | Byte mode: 0 = index port, 1 = data port |
| cfg_word | input | 1 | 1 = 16-bit write carrying index (low byte) and data (high byte) |
| cfg_wdata | input | 16 | Register bus write data |
| cfg_rdata | output | 8 | Value of the register the index selects |
| cpu_req | input | 1 | CPU access valid |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte returned from the selected plane |
| plane_rdata | input | 32 | Read bytes of planes 3..0 |
| plane_we | output | 4 | Per-plane write enable |
| plane_addr | output | ADDR_W | Offset inside each plane |
| plane_wdata | output | 8 | Byte written to enabled planes |

## Verification
The bench targets the following failure modes:

- A router that swaps the even/odd plane pairing would write character codes into the attribute plane.
- A router that forgets the shift in odd/even mode would spread text across twice the plane space.
- A design that lets bit 2 win over bit 3 would treat a chained access as sequential and light several planes.
- Writes issued during the hold are checked, because a leaking hold machine would corrupt planes while the layout is half-programmed.
- Readbacks of undefined indices and of over-wide values show whether stray bits are kept.
- A full switch from text layout to glyph layout and back, with the read-plane path in each, catches a read mux that ignores the address bit in odd/even mode.

// File: rtl/plane_router_pkg.sv
package plane_router_pkg;

    localparam int NPLANES = 4;
    localparam int BYTE_W  = 8;

    localparam logic [7:0] IDX_CTL  = 8'd0;
    localparam logic [7:0] IDX_MASK = 8'd2;
    localparam logic [7:0] IDX_MODE = 8'd4;
    localparam logic [7:0] IDX_RSEL = 8'd5;

    localparam logic [1:0] CTL_RST  = 2'b11;
    localparam logic [3:0] MASK_RST = 4'h3;
    localparam logic [3:0] MODE_RST = 4'h2;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_SYNC_HOLD  = 2'd1,
        ST_ASYNC_HOLD = 2'd2
    } hold_state_e;

    typedef enum logic [1:0] {
        MAP_ODDEVEN = 2'd0,
        MAP_SEQ     = 2'd1,
        MAP_CHAIN4  = 2'd2
    } map_mode_e;

endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import plane_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_port,
    input  logic        cfg_word,
    input  logic [15:0] cfg_wdata,
    output logic [7:0]  cfg_rdata,
    output logic [1:0]  ctl_q,
    output logic [3:0]  mask_q,
    output logic [3:0]  mode_q,
    output logic [1:0]  rsel_q,
    output logic        ctl_wr,
    output logic [1:0]  ctl_wval
);

    logic [7:0] idx_q;
    logic       idx_wr;
    logic       dat_wr;
    logic [7:0] wr_idx;
    logic [7:0] wr_dat;

    always_comb begin
        idx_wr = cfg_we && (cfg_word || !cfg_port);
        dat_wr = cfg_we && (cfg_word || cfg_port);
        wr_idx = cfg_word ? cfg_wdata[7:0]  : idx_q;
        wr_dat = cfg_word ? cfg_wdata[15:8] : cfg_wdata[7:0];
    end

    assign ctl_wr   = dat_wr && (wr_idx == IDX_CTL);
    assign ctl_wval = wr_dat[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ctl_q  <= CTL_RST;
            mask_q <= MASK_RST;
            mode_q <= MODE_RST;
            rsel_q <= '0;
        end else begin
            if (idx_wr) begin
                idx_q <= cfg_wdata[7:0];
            end
            if (dat_wr) begin
                unique case (wr_idx)
                    IDX_CTL:  ctl_q  <= wr_dat[1:0];
                    IDX_MASK: mask_q <= wr_dat[3:0];
                    IDX_MODE: mode_q <= wr_dat[3:0];
                    IDX_RSEL: rsel_q <= wr_dat[1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (idx_q)
            IDX_CTL:  cfg_rdata = {6'd0, ctl_q};
            IDX_MASK: cfg_rdata = {4'd0, mask_q};
            IDX_MODE: cfg_rdata = {4'd0, mode_q};
            IDX_RSEL: cfg_rdata = {6'd0, rsel_q};
            default:  cfg_rdata = 8'd0;
        endcase
    end

endmodule

// File: rtl/seq_hold_fsm.sv
module seq_hold_fsm
    import plane_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [1:0]  ctl_wval,
    output hold_state_e state_q,
    output logic        access_en
);

    hold_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            if (!ctl_wval[0]) begin
                state_d = ST_ASYNC_HOLD;
            end else if (!ctl_wval[1]) begin
                state_d = ST_SYNC_HOLD;
            end else begin
                state_d = ST_RUN;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:        access_en = 1'b1;
            ST_SYNC_HOLD:  access_en = 1'b0;
            ST_ASYNC_HOLD: access_en = 1'b0;
            default:       access_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/plane_addr_map.sv
module plane_addr_map
    import plane_router_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [3:0]                  mask_q,
    input  logic [3:0]                  mode_q,
    input  logic [1:0]                  rsel_q,
    input  logic                        access_en,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [NPLANES*BYTE_W-1:0]   plane_rdata,
    output logic [NPLANES-1:0]          plane_we,
    output logic [ADDR_W-1:0]           plane_addr,
    output logic [BYTE_W-1:0]           cpu_rdata
);

    localparam int PSEL_W = $clog2(NPLANES);

    map_mode_e           map_mode;
    logic [NPLANES-1:0]  hit;
    logic [PSEL_W-1:0]   rd_plane;
    logic                wr_go;

    always_comb begin
        if (mode_q[3]) begin
            map_mode = MAP_CHAIN4;
        end else if (mode_q[2]) begin
            map_mode = MAP_SEQ;
        end else begin
            map_mode = MAP_ODDEVEN;
        end
    end

    always_comb begin
        unique case (map_mode)
            MAP_CHAIN4: begin
                plane_addr = cpu_addr >> 2;
                rd_plane   = cpu_addr[1:0];
            end
            MAP_SEQ: begin
                plane_addr = cpu_addr;
                rd_plane   = rsel_q;
            end
            default: begin
                plane_addr = cpu_addr >> 1;
                rd_plane   = {rsel_q[1], cpu_addr[0]};
            end
        endcase
    end

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        always_comb begin
            unique case (map_mode)
                MAP_CHAIN4: hit[p] = (cpu_addr[1:0] == p[1:0]);
                MAP_SEQ:    hit[p] = 1'b1;
                default:    hit[p] = (cpu_addr[0] == p[0]);
            endcase
        end
    end

    assign wr_go     = access_en && cpu_req && cpu_we;
    assign plane_we  = wr_go ? (hit & mask_q) : '0;
    assign cpu_rdata = plane_rdata[rd_plane*BYTE_W +: BYTE_W];

endmodule

// File: rtl/plane_access_router.sv
module plane_access_router
    import plane_router_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_port,
    input  logic              cfg_word,
    input  logic [15:0]       cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic [31:0]       plane_rdata,
    output logic [3:0]        plane_we,
    output logic [ADDR_W-1:0] plane_addr,
    output logic [7:0]        plane_wdata
);

    logic [1:0]  ctl_q;
    logic [3:0]  mask_q;
    logic [3:0]  mode_q;
    logic [1:0]  rsel_q;
    logic        ctl_wr;
    logic [1:0]  ctl_wval;
    logic        access_en;
    hold_state_e hold_state;

    cfg_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_port  (cfg_port),
        .cfg_word  (cfg_word),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl_q     (ctl_q),
        .mask_q    (mask_q),
        .mode_q    (mode_q),
        .rsel_q    (rsel_q),
        .ctl_wr    (ctl_wr),
        .ctl_wval  (ctl_wval)
    );

    seq_hold_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wval  (ctl_wval),
        .state_q   (hold_state),
        .access_en (access_en)
    );

    plane_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .mask_q      (mask_q),
        .mode_q      (mode_q),
        .rsel_q      (rsel_q),
        .access_en   (access_en),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .plane_rdata (plane_rdata),
        .plane_we    (plane_we),
        .plane_addr  (plane_addr),
        .cpu_rdata   (cpu_rdata)
    );

    assign plane_wdata = cpu_wdata;

endmodule

// File: rtl/plane_access_router_chk.sv
module plane_access_router_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_word,
    input logic [15:0]       cfg_wdata,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [3:0]        plane_we,
    input logic [ADDR_W-1:0] plane_addr,
    input logic              access_en,
    input logic [3:0]        mask_q,
    input logic [3:0]        mode_q
);

    AST_HOLD_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        !access_en |-> (plane_we == 4'd0)); // R4

    AST_SYNC_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_word && cfg_wdata == 16'h0100) |=> !access_en); // R4

    AST_RUN_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_word && cfg_wdata == 16'h0300) |=> access_en); // R4

    AST_EVEN_TO_EVEN_PLANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[3] && !mode_q[2] && !cpu_addr[0]) |-> ((plane_we & 4'b1010) == 4'd0)); // R6

    AST_WE_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((plane_we & ~mask_q) == 4'd0)); // R7

    AST_SEQ_ADDR_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[3] && mode_q[2]) |-> (plane_addr == cpu_addr)); // R7

    AST_CHAIN_SINGLE_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[3] |-> $onehot0(plane_we)); // R8

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && cpu_we) |-> (plane_we == 4'd0)); // R10

endmodule

bind plane_access_router plane_access_router_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_word   (cfg_word),
    .cfg_wdata  (cfg_wdata),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .plane_we   (plane_we),
    .plane_addr (plane_addr),
    .access_en  (access_en),
    .mask_q     (mask_q),
    .mode_q     (mode_q)
);

// File: tb/plane_access_router_test.sv
`timescale 1ns/1ps
module plane_access_router_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_port = 1'b0;
    logic          cfg_word = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic [31:0]   plane_rdata;
    logic [3:0]    plane_we;
    logic [AW-1:0] plane_addr;
    logic [7:0]    plane_wdata;

    always #2.5 clk = ~clk;
    assign plane_rdata = 32'hD3C2_B1A0;

    plane_access_router #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_word(cfg_word),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .plane_rdata(plane_rdata), .plane_we(plane_we),
        .plane_addr(plane_addr), .plane_wdata(plane_wdata)
    );

    typedef struct {
        string         tag;
        bit            is_cfg;
        logic [3:0]    we;
        logic [AW-1:0] pa;
        logic [7:0]    rd;
        logic [7:0]    wd;
    } item_t;

    item_t sbq[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // bench-side register model (from the requirements)
    logic [7:0] m_idx  = 8'd0;
    logic [1:0] m_ctl  = 2'b11;
    logic [3:0] m_mask = 4'h3;
    logic [3:0] m_mode = 4'h2;
    logic [1:0] m_rsel = 2'd0;

    function automatic logic [7:0] reg_model(input logic [7:0] idx);
        case (idx)
            8'd0: return {6'd0, m_ctl};
            8'd2: return {4'd0, m_mask};
            8'd4: return {4'd0, m_mode};
            8'd5: return {6'd0, m_rsel};
            default: return 8'd0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] idx, input logic [7:0] dat);
        case (idx)
            8'd0: m_ctl  = dat[1:0];
            8'd2: m_mask = dat[3:0];
            8'd4: m_mode = dat[3:0];
            8'd5: m_rsel = dat[1:0];
            default: ;
        endcase
    endtask

    task automatic idle_bus();
        cfg_we = 1'b0; cfg_word = 1'b0; cfg_port = 1'b0;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic word_wr(input logic [7:0] idx, input logic [7:0] dat);
        @(negedge clk);
        idle_bus();
        cfg_we = 1'b1; cfg_word = 1'b1; cfg_wdata = {dat, idx};
        m_idx = idx;
        model_write(idx, dat);
    endtask

    task automatic byte_wr(input logic port, input logic [7:0] dat);
        @(negedge clk);
        idle_bus();
        cfg_we = 1'b1; cfg_port = port; cfg_wdata = {8'hEE, dat};
        if (!port) m_idx = dat;
        else       model_write(m_idx, dat);
    endtask

    task automatic check_reg(input logic [7:0] idx, input string tag);
        item_t it;
        byte_wr(1'b0, idx);
        @(negedge clk);
        idle_bus();
        it.tag = tag; it.is_cfg = 1'b1; it.rd = reg_model(idx);
        it.we = '0; it.pa = '0; it.wd = '0;
        sbq.push_back(it);
    endtask

    task automatic check_cur(input string tag);
        item_t it;
        @(negedge clk);
        idle_bus();
        it.tag = tag; it.is_cfg = 1'b1; it.rd = reg_model(m_idx);
        it.we = '0; it.pa = '0; it.wd = '0;
        sbq.push_back(it);
    endtask

    task automatic cpu_op(input logic req, input logic we, input logic [AW-1:0] a,
                          input logic [7:0] wd, input string tag);
        item_t it;
        logic [1:0] p;
        @(negedge clk);
        idle_bus();
        cpu_req = req; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        it.tag = tag; it.is_cfg = 1'b0; it.wd = wd;
        if (m_mode[3]) begin
            it.we = 4'b0001 << a[1:0];
            it.pa = a >> 2;
            p = a[1:0];
        end else if (!m_mode[2]) begin
            it.we = a[0] ? 4'b1010 : 4'b0101;
            it.pa = a >> 1;
            p = {m_rsel[1], a[0]};
        end else begin
            it.we = 4'b1111;
            it.pa = a;
            p = m_rsel;
        end
        it.we = it.we & m_mask;
        if (!(req && we && m_ctl == 2'b11)) it.we = 4'd0;
        it.rd = plane_rdata[p*8 +: 8];
        sbq.push_back(it);
    endtask

    // monitor: pop expected items and compare away from the clock edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                n_vec++;
                if (it.is_cfg) begin
                    if (cfg_rdata !== it.rd) begin
                        n_bad++;
                        $display("FAIL %s: cfg_rdata=%02h expected %02h", it.tag, cfg_rdata, it.rd);
                    end
                end else if (plane_we !== it.we || plane_addr !== it.pa ||
                             cpu_rdata !== it.rd || plane_wdata !== it.wd) begin
                    n_bad++;
                    $display("FAIL %s: we=%b addr=%h rd=%h wd=%h expected we=%b addr=%h rd=%h wd=%h",
                             it.tag, plane_we, plane_addr, cpu_rdata, plane_wdata,
                             it.we, it.pa, it.rd, it.wd);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check_cur("R1 ctl after reset");
        check_reg(8'd2, "R1 mask after reset");
        check_reg(8'd4, "R1 mode after reset");
        check_reg(8'd5, "R1 rsel after reset");

        // R6 text layout, odd/even
        cpu_op(1, 1, 16'h0010, 8'h41, "R6 even addr to plane 0");
        cpu_op(1, 1, 16'h0011, 8'h07, "R6 odd addr to plane 1");
        cpu_op(1, 0, 16'h0011, 8'h00, "R9 odd/even read plane 1");
        word_wr(8'd2, 8'h0F);
        cpu_op(1, 1, 16'h0022, 8'h55, "R6 even addr planes 0 and 2");
        word_wr(8'd5, 8'h02);
        cpu_op(1, 0, 16'h0001, 8'h00, "R9 odd/even read with select 2 picks plane 3");

        // R4/R5 sync hold, glyph layout prolog
        word_wr(8'd0, 8'h01);
        cpu_op(1, 1, 16'h0040, 8'hAA, "R4 sync hold blocks write");
        check_cur("R4 ctl reads 01 in hold");
        word_wr(8'd2, 8'h04);
        word_wr(8'd4, 8'h07);
        check_reg(8'd2, "R5 mask write in hold");
        check_reg(8'd4, "R5 mode write in hold");
        cpu_op(1, 1, 16'h0041, 8'hAA, "R4 still held after mode change");
        word_wr(8'd0, 8'h03);
        word_wr(8'd5, 8'h02);
        cpu_op(1, 1, 16'h1234, 8'h3C, "R7 sequential write to glyph plane");
        cpu_op(1, 0, 16'h1235, 8'h00, "R9 sequential read plane 2");
        word_wr(8'd2, 8'h0B);
        cpu_op(1, 1, 16'h0FFF, 8'h99, "R7 mask passes through");

        // R4 async hold
        word_wr(8'd0, 8'h02);
        cpu_op(1, 1, 16'h0002, 8'h11, "R4 async hold blocks write");
        check_cur("R4 ctl reads 02");
        word_wr(8'd0, 8'h00);
        cpu_op(1, 1, 16'h0003, 8'h11, "R4 ctl 00 blocks write");
        word_wr(8'd0, 8'h03);

        // R8 chained
        word_wr(8'd2, 8'h0F);
        word_wr(8'd4, 8'h08);
        cpu_op(1, 1, 16'h0007, 8'h77, "R8 chain addr 7 plane 3");
        cpu_op(1, 0, 16'h0006, 8'h00, "R8 chain read plane 2");
        word_wr(8'd4, 8'h0C);
        cpu_op(1, 1, 16'h0105, 8'h12, "R8 chain wins over bit 2");
        word_wr(8'd2, 8'h0E);
        cpu_op(1, 1, 16'h0104, 8'h12, "R8 chain masked plane 0");

        // R2/R3 register bus corner cases
        word_wr(8'd1, 8'hFF);
        check_cur("R3 unused index 1 reads zero");
        word_wr(8'd7, 8'hFF);
        check_cur("R3 unused index 7 reads zero");
        word_wr(8'd2, 8'hFF);
        check_cur("R3 mask upper bits zero");
        byte_wr(1'b0, 8'd2);
        byte_wr(1'b1, 8'h05);
        check_cur("R2 byte index then data");
        byte_wr(1'b0, 8'd6);
        byte_wr(1'b1, 8'hFF);
        check_reg(8'd2, "R2 write to unused index leaves mask");

        // R10 non-write and idle
        cpu_op(1, 0, 16'h0101, 8'hC3, "R10 read raises no enable");
        cpu_op(0, 1, 16'h0101, 8'h5A, "R10 no request raises no enable");

        // epilog back to text layout
        word_wr(8'd0, 8'h01);
        word_wr(8'd2, 8'h03);
        word_wr(8'd4, 8'h03);
        word_wr(8'd0, 8'h03);
        word_wr(8'd5, 8'h00);
        cpu_op(1, 1, 16'h0003, 8'h1F, "R6 back to text odd addr");
        cpu_op(1, 0, 16'h0002, 8'h00, "R9 back to text read plane 0");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule